// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This unit is the wide-multiply execution stage of a processor datapath. It takes two 32-bit operands and two 32-bit accumulator words (high and low). It forms a 64-bit result and returns it as a high word and a low word, along with a write strobe, a negative flag, a zero flag and an illegal-operation indication. A 4-bit operation code picks the mode. Three control bits then choose signed or unsigned multiplication, whether to accumulate, and whether to update the flags.

Codes 8 to 15 select the ordinary long multiply. This mode can be signed or unsigned. It can optionally add the 64-bit value formed from both accumulator words, and it can optionally update the flags. Code 4 selects the double-accumulate mode. This mode always multiplies unsigned and adds both accumulator words to the product as two separate zero-extended 32-bit values. Every other code is rejected as illegal.

Operands enter through a valid/ready handshake. Results leave through a second valid/ready pair after a fixed two-stage pipeline. A result that is not taken holds the whole pipeline.

Top module: `long_mac_unit`

## Requirements
- R1: Code 4 selects double-accumulate. Codes 8 to 15 select long multiply. Every other code gives a result with `op_illegal`=1, `res_wr`=0, both result words zero, `flag_wr`=0 and unchanged flags.
- R2: In long multiply with `sel_signed`=0, the result is the unsigned 64-bit product of `src_a` and `src_b`.
- R3: In long multiply with `sel_signed`=1, the result is the two's-complement 64-bit product of `src_a` and `src_b`.
- R4: In long multiply with `sel_accum`=1, the value {`acc_hi`,`acc_lo`} is added to the product modulo 2^64, and any carry out of bit 63 is dropped.
- R5: In long multiply with `sel_flags`=1, `flag_wr` is 1 with the result, `flag_n` takes result bit 63, and `flag_z` is 1 only when all 64 result bits are zero.
- R6: When no flag update is requested, `flag_wr` is 0 and `flag_n` and `flag_z` keep their previous values.
- R7: In double-accumulate, the result is the unsigned product plus zero-extended `acc_lo` plus zero-extended `acc_hi`. `sel_signed` has no effect in this mode.
- R8: Double-accumulate ignores `sel_accum` and `sel_flags` and never updates the flags (`flag_wr`=0).
- R9: Double-accumulate with every operand and accumulator word at all-ones yields exactly 2^64-1.
- R10: An operand set accepted at a rising edge (with `in_valid` and `in_ready` both high) appears with `out_valid`=1 after the next rising edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds.
- R11: After reset, `out_valid`, `res_wr`, `op_illegal`, `flag_wr`, `flag_n` and `flag_z` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can accept an operand set |
| op_code | input | 4 | Operation code |
| sel_signed | input | 1 | Signed multiply (long multiply only) |
| sel_accum | input | 1 | Add 64-bit accumulator (long multiply only) |
| sel_flags | input | 1 | Update flags (long multiply only) |
| src_a | input | 32 | Multiplier operand |
| src_b | input | 32 | Multiplicand operand |
| acc_hi | input | 32 | Accumulator high word / second addend |
| acc_lo | input | 32 | Accumulator low word / first addend |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res_hi | output | 32 | Result bits 63..32 |
| res_lo | output | 32 | Result bits 31..0 |
| res_wr | output | 1 | Result is to be written back |
| op_illegal | output | 1 | Operation code was rejected |
| flag_wr | output | 1 | Flags were updated with this result |
| flag_n | output | 1 | Negative flag state |
| flag_z | output | 1 | Zero flag state |

## Verification
Every result, write strobe, illegal indication and flag is registered in the second stage. Each one therefore appears two rising edges after the operands are driven: the edge that accepts them and the edge after it. The bench drives inputs on the falling edge. It checks that `out_valid` is still low at the falling edge after the accepting edge, and it samples all results at the falling edge after the second edge. The stall scenario holds `out_ready` low for several cycles and samples each held output at falling edges until release. It then confirms that `out_valid` drops one edge after release.

// File: rtl/lmac_pkg.sv
// Shared definitions for the long multiply-accumulate unit.
// Assumes a 4-bit operation code; the double-accumulate code is fixed.
package lmac_pkg;
    typedef enum logic [1:0] {
        KIND_ILL  = 2'd0,
        KIND_LONG = 2'd1,
        KIND_DACC = 2'd2
    } op_kind_t;

    localparam int unsigned OPW = 4;
    localparam logic [OPW-1:0] OP_DACC = 4'd4;
endpackage

// File: rtl/lmac_decode.sv
// Operation decoder: classifies the operation code and qualifies the
// control bits so that only long multiply may be signed, accumulate the
// 64-bit value or update flags. Purely combinational.
module lmac_decode
    import lmac_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    input  logic           sel_signed,
    input  logic           sel_accum,
    input  logic           sel_flags,
    output op_kind_t       kind,
    output logic           use_signed,
    output logic           add_full,
    output logic           upd_flags
);
    // Classify the code and gate the control bits by mode.
    always_comb begin
        if (op_code == OP_DACC) begin
            kind = KIND_DACC;
        end else if (op_code[OPW-1]) begin
            kind = KIND_LONG;
        end else begin
            kind = KIND_ILL;
        end
        use_signed = (kind == KIND_LONG) && sel_signed;
        add_full   = (kind == KIND_LONG) && sel_accum;
        upd_flags  = (kind == KIND_LONG) && sel_flags;
    end
endmodule

// File: rtl/lmac_mul_stage.sv
// First pipeline stage: forms the 2W-bit product and the 2W-bit addend
// (full accumulator or the sum of two zero-extended words) and registers
// them with the decoded control. Advances only when 'adv' is high.
module lmac_mul_stage
    import lmac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            in_valid,
    input  op_kind_t        kind,
    input  logic            use_signed,
    input  logic            add_full,
    input  logic            upd_flags,
    input  logic [W-1:0]    src_a,
    input  logic [W-1:0]    src_b,
    input  logic [W-1:0]    acc_hi,
    input  logic [W-1:0]    acc_lo,
    output logic            s1_valid,
    output op_kind_t        s1_kind,
    output logic            s1_upd,
    output logic [2*W-1:0]  s1_prod,
    output logic [2*W-1:0]  s1_addend
);
    localparam int unsigned DW = 2 * W;

    logic signed [W:0]    ext_a;
    logic signed [W:0]    ext_b;
    logic signed [DW+1:0] full_prod;
    logic [DW-1:0]        addend;

    // Extend each operand by one bit, sign or zero, and multiply signed.
    always_comb begin
        ext_a     = {use_signed & src_a[W-1], src_a};
        ext_b     = {use_signed & src_b[W-1], src_b};
        full_prod = ext_a * ext_b;
    end

    // Select the addend by mode; double-accumulate sums two narrow words.
    always_comb begin
        if (kind == KIND_DACC) begin
            addend = {{W{1'b0}}, acc_hi} + {{W{1'b0}}, acc_lo};
        end else if (add_full) begin
            addend = {acc_hi, acc_lo};
        end else begin
            addend = '0;
        end
    end

    // Register stage-one results when the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_kind   <= KIND_ILL;
            s1_upd    <= 1'b0;
            s1_prod   <= '0;
            s1_addend <= '0;
        end else if (adv) begin
            s1_valid  <= in_valid;
            s1_kind   <= kind;
            s1_upd    <= upd_flags;
            s1_prod   <= full_prod[DW-1:0];
            s1_addend <= addend;
        end
    end
endmodule

// File: rtl/lmac_acc_stage.sv
// Second pipeline stage: adds product and addend modulo 2^(2W), then
// registers the result, write strobe, illegal indication and flags.
// Flags are state and change only on a flag-updating long multiply.
module lmac_acc_stage
    import lmac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            s1_valid,
    input  op_kind_t        s1_kind,
    input  logic            s1_upd,
    input  logic [2*W-1:0]  s1_prod,
    input  logic [2*W-1:0]  s1_addend,
    output logic            out_valid,
    output logic [2*W-1:0]  result,
    output logic            res_wr,
    output logic            op_illegal,
    output logic            flag_wr,
    output logic            flag_n,
    output logic            flag_z
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] sum;
    logic          legal;

    // Wrap-around add; the carry out of the top bit is dropped.
    always_comb begin
        sum   = s1_prod + s1_addend;
        legal = s1_valid && (s1_kind != KIND_ILL);
    end

    // Register the outputs and update flags only when requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            res_wr     <= 1'b0;
            op_illegal <= 1'b0;
            flag_wr    <= 1'b0;
            flag_n     <= 1'b0;
            flag_z     <= 1'b0;
        end else if (adv) begin
            out_valid  <= s1_valid;
            result     <= legal ? sum : '0;
            res_wr     <= legal;
            op_illegal <= s1_valid && (s1_kind == KIND_ILL);
            flag_wr    <= legal && s1_upd;
            if (legal && s1_upd) begin
                flag_n <= sum[DW-1];
                flag_z <= (sum == '0);
            end
        end
    end
endmodule

// File: rtl/long_mac_unit.sv
// Top of the long multiply-accumulate unit: decoder, product stage and
// accumulate stage joined by a single pipeline-wide advance signal.
// Assumes the consumer may stall with out_ready; a stall holds all stages.
module long_mac_unit
    import lmac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [3:0]     op_code,
    input  logic           sel_signed,
    input  logic           sel_accum,
    input  logic           sel_flags,
    input  logic [W-1:0]   src_a,
    input  logic [W-1:0]   src_b,
    input  logic [W-1:0]   acc_hi,
    input  logic [W-1:0]   acc_lo,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W-1:0]   res_hi,
    output logic [W-1:0]   res_lo,
    output logic           res_wr,
    output logic           op_illegal,
    output logic           flag_wr,
    output logic           flag_n,
    output logic           flag_z
);
    localparam int unsigned DW = 2 * W;

    op_kind_t      kind;
    op_kind_t      s1_kind;
    logic          use_signed;
    logic          add_full;
    logic          upd_flags;
    logic          adv;
    logic          s1_valid;
    logic          s1_upd;
    logic [DW-1:0] s1_prod;
    logic [DW-1:0] s1_addend;
    logic [DW-1:0] result;

    // Pipeline advances unless a presented result is being held.
    always_comb begin
        adv      = !out_valid || out_ready;
        in_ready = adv;
        res_hi   = result[DW-1:W];
        res_lo   = result[W-1:0];
    end

    lmac_decode u_dec (
        .op_code    (op_code),
        .sel_signed (sel_signed),
        .sel_accum  (sel_accum),
        .sel_flags  (sel_flags),
        .kind       (kind),
        .use_signed (use_signed),
        .add_full   (add_full),
        .upd_flags  (upd_flags)
    );

    lmac_mul_stage #(.W(W)) u_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .in_valid   (in_valid),
        .kind       (kind),
        .use_signed (use_signed),
        .add_full   (add_full),
        .upd_flags  (upd_flags),
        .src_a      (src_a),
        .src_b      (src_b),
        .acc_hi     (acc_hi),
        .acc_lo     (acc_lo),
        .s1_valid   (s1_valid),
        .s1_kind    (s1_kind),
        .s1_upd     (s1_upd),
        .s1_prod    (s1_prod),
        .s1_addend  (s1_addend)
    );

    lmac_acc_stage #(.W(W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .s1_valid   (s1_valid),
        .s1_kind    (s1_kind),
        .s1_upd     (s1_upd),
        .s1_prod    (s1_prod),
        .s1_addend  (s1_addend),
        .out_valid  (out_valid),
        .result     (result),
        .res_wr     (res_wr),
        .op_illegal (op_illegal),
        .flag_wr    (flag_wr),
        .flag_n     (flag_n),
        .flag_z     (flag_z)
    );
endmodule

// File: rtl/lmac_checker.sv
// Port-level protocol and flag checks for long_mac_unit, bound to it.
// Assumes synchronous active-low reset; all checks are disabled in reset.
module lmac_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo,
    input logic         res_wr,
    input logic         op_illegal,
    input logic         flag_wr,
    input logic         flag_n,
    input logic         flag_z
);
    AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_illegal) |-> (!res_wr && !flag_wr && res_hi == '0 && res_lo == '0)); // R1

    AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> (out_valid && res_wr && flag_n == res_hi[W-1]
                     && flag_z == (res_hi == '0 && res_lo == '0))); // R5

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |-> ($stable(flag_n) && $stable(flag_z))); // R6

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_hi) && $stable(res_lo)
                                       && $stable(res_wr) && $stable(op_illegal))); // R10
endmodule

bind long_mac_unit lmac_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .res_hi     (res_hi),
    .res_lo     (res_lo),
    .res_wr     (res_wr),
    .op_illegal (op_illegal),
    .flag_wr    (flag_wr),
    .flag_n     (flag_n),
    .flag_z     (flag_z)
);

// File: tb/tb_long_mac_unit.sv
// Directed bench for long_mac_unit: one task per scenario, each checking
// its own results against a reference computed from the requirements.
module tb_long_mac_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  op_code = '0;
    logic        sel_signed = 1'b0;
    logic        sel_accum = 1'b0;
    logic        sel_flags = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] acc_hi = '0;
    logic [31:0] acc_lo = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] res_hi;
    logic [31:0] res_lo;
    logic        res_wr;
    logic        op_illegal;
    logic        flag_wr;
    logic        flag_n;
    logic        flag_z;

    int n_run = 0;
    int n_fail = 0;
    logic exp_n = 1'b0;
    logic exp_z = 1'b0;

    always #5 clk = ~clk;

    long_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_code(op_code), .sel_signed(sel_signed), .sel_accum(sel_accum),
        .sel_flags(sel_flags), .src_a(src_a), .src_b(src_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .out_valid(out_valid),
        .out_ready(out_ready), .res_hi(res_hi), .res_lo(res_lo),
        .res_wr(res_wr), .op_illegal(op_illegal), .flag_wr(flag_wr),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation and check latency, result, strobes and flags.
    task automatic do_op(input string req, input logic [3:0] op, input logic s,
                         input logic ac, input logic f, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] hi, input logic [31:0] lo);
        logic [63:0] exp_res;
        logic        is_long;
        logic        is_dacc;
        logic        upd;
        is_dacc = (op == 4'd4);
        is_long = op[3];
        if (is_dacc) begin
            exp_res = {32'b0, a} * {32'b0, b} + {32'b0, lo} + {32'b0, hi};
        end else if (is_long) begin
            if (s) exp_res = {{32{a[31]}}, a} * {{32{b[31]}}, b};
            else   exp_res = {32'b0, a} * {32'b0, b};
            if (ac) exp_res = exp_res + {hi, lo};
        end else begin
            exp_res = '0;
        end
        upd = is_long && f;
        if (upd) begin
            exp_n = exp_res[63];
            exp_z = (exp_res == 64'd0);
        end
        @(negedge clk);
        op_code = op; sel_signed = s; sel_accum = ac; sel_flags = f;
        src_a = a; src_b = b; acc_hi = hi; acc_lo = lo; in_valid = 1'b1;
        check({req, " R10 ready"}, {63'b0, in_ready}, 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R10 not yet valid"}, {63'b0, out_valid}, 64'd0);
        @(negedge clk);
        check({req, " R10 valid"}, {63'b0, out_valid}, 64'd1);
        check({req, " result"}, {res_hi, res_lo}, exp_res);
        check({req, " R1 write"}, {63'b0, res_wr}, {63'b0, is_long | is_dacc});
        check({req, " R1 illegal"}, {63'b0, op_illegal}, {63'b0, !(is_long | is_dacc)});
        check({req, " R5 R6 flag_wr"}, {63'b0, flag_wr}, {63'b0, upd});
        check({req, " R5 R6 flags"}, {62'b0, flag_n, flag_z}, {62'b0, exp_n, exp_z});
    endtask

    task automatic t_reset;
        check("R11 out_valid", {63'b0, out_valid}, 64'd0);
        check("R11 strobes", {61'b0, res_wr, op_illegal, flag_wr}, 64'd0);
        check("R11 flags", {62'b0, flag_n, flag_z}, 64'd0);
        check("R11 in_ready", {63'b0, in_ready}, 64'd1);
    endtask

    task automatic t_unsigned;
        do_op("R2 small", 4'd8, 1'b0, 1'b0, 1'b0, 32'd7, 32'd9, 32'd5, 32'd6);
        do_op("R2 big", 4'd12, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0);
        do_op("R2 mixed", 4'd15, 1'b0, 1'b0, 1'b0, 32'h8000_0001, 32'h0001_0003, 32'd1, 32'd1);
    endtask

    task automatic t_signed;
        do_op("R3 neg*pos", 4'd9, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFD, 32'd1000, 32'd0, 32'd0);
        do_op("R3 neg*neg", 4'd10, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0);
    endtask

    task automatic t_accum;
        do_op("R4 plain", 4'd11, 1'b0, 1'b1, 1'b0, 32'd3, 32'd4, 32'h0000_0001, 32'hFFFF_FFFF);
        do_op("R4 wrap", 4'd8, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_op("R4 signed", 4'd13, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd1);
    endtask

    task automatic t_flags;
        do_op("R5 negative", 4'd9, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd5, 32'd0, 32'd0);
        do_op("R6 hold", 4'd8, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, 32'd0);
        do_op("R5 zero", 4'd14, 1'b0, 1'b1, 1'b1, 32'd0, 32'd77, 32'd0, 32'd0);
        do_op("R5 wrap to zero", 4'd9, 1'b1, 1'b1, 1'b1, 32'd1, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        do_op("R5 positive", 4'd8, 1'b0, 1'b0, 1'b1, 32'd2, 32'd3, 32'd0, 32'd0);
    endtask

    task automatic t_dacc;
        do_op("R7 basic", 4'd4, 1'b0, 1'b0, 1'b0, 32'd10, 32'd20, 32'd3, 32'd4);
        do_op("R7 signed bit ignored", 4'd4, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFE, 32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF);
        do_op("R8 flag set first", 4'd8, 1'b0, 1'b0, 1'b1, 32'd0, 32'd1, 32'd0, 32'd0);
        do_op("R8 ctrl ignored", 4'd4, 1'b1, 1'b1, 1'b1, 32'hFFFF_0000, 32'h0001_0000, 32'hFFFF_FFFF, 32'h0000_0010);
        do_op("R9 all ones", 4'd4, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_illegal;
        do_op("R1 flag set first", 4'd10, 1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd0);
        for (int c = 0; c < 8; c++) begin
            if (c != 4) do_op("R1 illegal code", c[3:0], 1'b1, 1'b1, 1'b1, 32'd5, 32'd6, 32'd7, 32'd8);
        end
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        op_code = 4'd8; sel_signed = 1'b0; sel_accum = 1'b0; sel_flags = 1'b0;
        src_a = 32'd1234; src_b = 32'd1000; acc_hi = '0; acc_lo = '0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 stall valid", {63'b0, out_valid}, 64'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 stall held", {res_hi, res_lo}, 64'd1234000);
            check("R10 stall valid held", {62'b0, out_valid, in_ready}, 64'd2);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check("R10 release", {63'b0, out_valid}, 64'd0);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_accum();
        t_flags();
        t_dacc();
        t_illegal();
        t_stall();
        finish_up();
    end
endmodule